// File: doc/BRIEF.md
# Dual-Pattern Truth-Table Gate Evaluator

This block evaluates one library gate for two test patterns in a single table read and then injects a stuck-at fault into the result. The gate library is an inverter plus NAND, NOR, AND and OR gates with two, three or four inputs. Every gate input is a 2-bit pin word. Bit 0 carries the first pattern's value and bit 1 carries the second pattern's value. A truth-table memory stores both pattern outputs in each 2-bit entry, so a single read answers both patterns.

Each request carries the base offset of the gate's region in the table, four pin words and two fault masks: a keep mask and a set mask. The result is `(entry & keep) | set`, registered one cycle after the request is accepted. A host write port loads the table. Writes take priority over requests, so the table is only ever read while no load is in progress. Inputs that a gate does not use are driven to 0 by the requester, which keeps the address inside the gate's own region.

Top module: `lut_gate_eval`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0 and `req_ready` is 1 while no table write is presented.
- R2: The entry read is at index `req_base + a + 4*b + 16*c + 64*d`, where `req_pins` packs a in [1:0], b in [3:2], c in [5:4] and d in [7:6]. Result bit 0 belongs to pattern 0 and bit 1 belongs to pattern 1.
- R3: `res_valid` is 1 in exactly the cycle after a request is accepted (`req_valid && req_ready`), and 0 in every other cycle.
- R4: `res_bits = (entry & req_keep) | req_set`. The mask codes are: no fault keep=11, set=00; stuck-at-0 keep=00, set=00; stuck-at-1 set=11 with any keep value.
- R5: With the table laid out as INV at 0, NAND2 at 4, NAND3 at 20, NAND4 at 84, NOR2 at 340, NOR3 at 356, NOR4 at 420, AND2 at 676, AND3 at 692, AND4 at 756, OR2 at 1012, OR3 at 1028 and OR4 at 1092 (1348 entries in total), every gate and every input combination evaluates to its logic function under all three mask codes.
- R6: A table write of `tbl_wr_data` to `tbl_wr_addr` is visible to a request accepted in any later cycle.
- R7: In a cycle with `tbl_wr_en` high, `req_ready` is 0, the request is not taken, and `res_valid` is 0 in the following cycle. The request is accepted once the write drops.
- R8: An index at or beyond 1348 reads an entry of 00, which is then masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 11 | Table write index |
| tbl_wr_data | input | 2 | Entry value: both pattern outputs |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_base | input | 11 | Base offset of the gate's region |
| req_pins | input | 8 | Four 2-bit pin words, a in the low bits |
| req_keep | input | 2 | AND mask applied to the entry |
| req_set | input | 2 | OR mask applied after the AND mask |
| res_valid | output | 1 | Result valid |
| res_bits | output | 2 | Masked outputs of the two patterns |

## Verification
A table load and a gate request can arrive in the same cycle. The bench provokes this by raising the write strobe and a request together at one clock edge. It expects `req_ready` to drop during that cycle and no result to appear in the next one. It then lowers the write strobe while holding the request, and expects exactly one result. That result must reflect the value just written. The bench also rewrites an entry and reads it back straight away, to show that the write and the subsequent read order correctly.

// File: rtl/lgev_pkg.sv
// Package: shared constants and helpers for the dual-pattern gate evaluator.
// Assumes two patterns per pin word and at most four gate inputs.
package lgev_pkg;

    localparam int LG_PAT    = 2;   // patterns packed per pin word
    localparam int LG_MAX_IN = 4;   // widest gate in the library

    // Region size of an n-input gate: one entry per pin-word combination.
    function automatic int lg_region(input int n_in);
        return 1 << (LG_PAT * n_in);
    endfunction

    // Total table depth: an inverter plus four families of 2..MAX_IN inputs.
    function automatic int lg_depth();
        int acc;
        acc = lg_region(1);
        for (int n = 2; n <= LG_MAX_IN; n++) acc += 4 * lg_region(n);
        return acc;
    endfunction

    localparam int LG_DEPTH  = lg_depth();
    localparam int LG_ADDR_W = $clog2(LG_DEPTH);

    typedef enum logic [3:0] {
        GK_INV,
        GK_NAND2, GK_NAND3, GK_NAND4,
        GK_NOR2,  GK_NOR3,  GK_NOR4,
        GK_AND2,  GK_AND3,  GK_AND4,
        GK_OR2,   GK_OR3,   GK_OR4
    } gate_kind_e;

    // Inputs of a gate kind.
    function automatic int lg_inputs(input gate_kind_e k);
        if (k == GK_INV) return 1;
        return 2 + ((int'(k) - 1) % 3);
    endfunction

    // Base offset of a gate kind: regions are stacked in enum order.
    function automatic int lg_base(input gate_kind_e k);
        int acc;
        acc = 0;
        for (int i = 0; i < int'(k); i++) acc += lg_region(lg_inputs(gate_kind_e'(i)));
        return acc;
    endfunction

endpackage

// File: rtl/lut_addr.sv
// Module: lut_addr
// Forms the table index from a region base and the packed pin words.
// Pin word i is weighted by (2^PAT)^i. Purely combinational.
// Assumes the sum never exceeds 2^(ADDR_W+1)-1 (base < 2^ADDR_W and
// NUM_IN*PAT <= ADDR_W).
module lut_addr #(
    parameter int NUM_IN = 4,
    parameter int PAT    = 2,
    parameter int DEPTH  = 1348,
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0]     base,
    input  logic [NUM_IN*PAT-1:0] pins,
    output logic [ADDR_W-1:0]     addr,
    output logic                  in_range
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] term [NUM_IN];
    logic [SUM_W-1:0] sum;

    // One weighted term per pin word.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_term
        assign term[i] = SUM_W'(pins[i*PAT +: PAT]) << (PAT * i);
    end

    // Add the weighted terms onto the region base.
    always_comb begin
        sum = {1'b0, base};
        for (int i = 0; i < NUM_IN; i++) sum = sum + term[i];
    end

    assign addr     = sum[ADDR_W-1:0];
    assign in_range = (sum < SUM_W'(DEPTH));

endmodule

// File: rtl/lut_table.sv
// Module: lut_table
// Truth-table store: one write port and one registered read port.
// Writes outside the depth are dropped. A read whose index is out of
// range returns zero. Assumes the caller never reads and writes in the
// same cycle.
module lut_table #(
    parameter int PAT    = 2,
    parameter int DEPTH  = 1348,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PAT-1:0]    wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_in_range,
    output logic [PAT-1:0]    rd_data
);
    logic [PAT-1:0] mem [DEPTH];
    logic           wr_ok;

    assign wr_ok = wr_en && (32'(wr_addr) < DEPTH);

    // Store the host's entry.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    // Registered read; out-of-range indices read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_in_range ? mem[rd_addr] : '0;
    end

    AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_in_range) |=> (rd_data == '0));                       // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (mem[$past(wr_addr)] == $past(wr_data)));                // R6

endmodule

// File: rtl/lut_mask_stage.sv
// Module: lut_mask_stage
// Output stage: captures the fault masks next to the table read and
// applies keep/set masking to the entry. Holds the result-valid flag.
// Assumes rd_data is the table read launched by the same load pulse.
module lut_mask_stage #(
    parameter int PAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [PAT-1:0] keep_mask,
    input  logic [PAT-1:0] set_mask,
    input  logic [PAT-1:0] rd_data,
    output logic           res_valid,
    output logic [PAT-1:0] res_bits
);
    logic [PAT-1:0] keep_q;
    logic [PAT-1:0] set_q;

    // Capture masks with the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
            set_q  <= '0;
        end else if (load) begin
            keep_q <= keep_mask;
            set_q  <= set_mask;
        end
    end

    // Result valid follows an accepted request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= load;
    end

    // Apply the fault-injection masks to both pattern bits.
    always_comb res_bits = (rd_data & keep_q) | set_q;

    AST_SA0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(keep_mask == '0 && set_mask == '0)) |-> (res_bits == '0)); // R4

    AST_SA1_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(set_mask == '1)) |-> (res_bits == '1));                   // R4

endmodule

// File: rtl/lut_gate_eval.sv
// Module: lut_gate_eval (top)
// Evaluates one library gate for two packed patterns with a single
// truth-table read, then injects stuck-at faults through keep/set masks.
// A table write has priority and stalls requests for that cycle.
// Assumes the requester zeroes the pin words a gate does not use.
module lut_gate_eval
    import lgev_pkg::*;
#(
    parameter int NUM_IN = LG_MAX_IN,
    parameter int PAT    = LG_PAT,
    parameter int DEPTH  = LG_DEPTH,
    parameter int ADDR_W = LG_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_wr_en,
    input  logic [ADDR_W-1:0]     tbl_wr_addr,
    input  logic [PAT-1:0]        tbl_wr_data,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [NUM_IN*PAT-1:0] req_pins,
    input  logic [PAT-1:0]        req_keep,
    input  logic [PAT-1:0]        req_set,
    output logic                  res_valid,
    output logic [PAT-1:0]        res_bits
);
    logic              accept;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_in_range;
    logic [PAT-1:0]    rd_data;

    // Loads own the table; requests wait while one is presented.
    assign req_ready = !tbl_wr_en;
    assign accept    = req_valid && req_ready;

    lut_addr #(
        .NUM_IN (NUM_IN),
        .PAT    (PAT),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base     (req_base),
        .pins     (req_pins),
        .addr     (rd_addr),
        .in_range (rd_in_range)
    );

    lut_table #(
        .PAT    (PAT),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_wr_en),
        .wr_addr     (tbl_wr_addr),
        .wr_data     (tbl_wr_data),
        .rd_en       (accept),
        .rd_addr     (rd_addr),
        .rd_in_range (rd_in_range),
        .rd_data     (rd_data)
    );

    lut_mask_stage #(
        .PAT (PAT)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .keep_mask (req_keep),
        .set_mask  (req_set),
        .rd_data   (rd_data),
        .res_valid (res_valid),
        .res_bits  (res_bits)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !res_valid);                                     // R1

    AST_RES_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req_valid && req_ready));                       // R3

    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_ready) |-> !res_valid);                     // R3

    AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |=> !res_valid);                                          // R7

endmodule

// File: tb/sim_lut_gate_eval.sv
module sim_lut_gate_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [10:0] tbl_wr_addr = '0;
    logic [1:0]  tbl_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_base = '0;
    logic [7:0]  req_pins = '0;
    logic [1:0]  req_keep = '0;
    logic [1:0]  req_set = '0;
    logic        res_valid;
    logic [1:0]  res_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lut_gate_eval u0 (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
        .req_pins(req_pins), .req_keep(req_keep), .req_set(req_set),
        .res_valid(res_valid), .res_bits(res_bits)
    );

    // Table layout and gate kinds: INV, NAND2-4, NOR2-4, AND2-4, OR2-4.
    localparam int BASES [13] = '{0, 4, 20, 84, 340, 356, 420, 676, 692, 756, 1012, 1028, 1092};
    localparam int NIN   [13] = '{1, 2, 3, 4, 2, 3, 4, 2, 3, 4, 2, 3, 4};
    localparam int OPS   [13] = '{0, 1, 1, 1, 2, 2, 2, 3, 3, 3, 4, 4, 4};

    // Directed vectors: {gate[17:14], pins[13:6], keep[5:4], set[3:2], expected[1:0]}.
    localparam logic [17:0] VEC [11] = '{
        {4'd2,  8'b00011111, 2'b11, 2'b00, 2'b10},
        {4'd2,  8'b00011111, 2'b00, 2'b00, 2'b00},
        {4'd2,  8'b00011111, 2'b01, 2'b11, 2'b11},
        {4'd0,  8'b00000001, 2'b11, 2'b00, 2'b10},
        {4'd6,  8'b00000000, 2'b11, 2'b00, 2'b11},
        {4'd7,  8'b00001011, 2'b11, 2'b00, 2'b10},
        {4'd12, 8'b10000000, 2'b11, 2'b00, 2'b10},
        {4'd4,  8'b00000001, 2'b11, 2'b00, 2'b10},
        {4'd9,  8'b11111111, 2'b11, 2'b00, 2'b11},
        {4'd3,  8'b11111111, 2'b11, 2'b00, 2'b00},
        {4'd3,  8'b11111111, 2'b10, 2'b11, 2'b11}
    };

    function automatic logic [1:0] ref_eval(input int g, input int idx);
        logic [1:0] r;
        for (int p = 0; p < 2; p++) begin
            logic all1, any1;
            all1 = 1'b1;
            any1 = 1'b0;
            for (int i = 0; i < NIN[g]; i++) begin
                logic b;
                b = 1'((idx >> (2 * i + p)) & 1);
                all1 = all1 & b;
                any1 = any1 | b;
            end
            case (OPS[g])
                0: r[p] = ~any1;
                1: r[p] = ~all1;
                2: r[p] = ~any1;
                3: r[p] = all1;
                default: r[p] = any1;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input int addr, input logic [1:0] data);
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = 11'(addr);
        tbl_wr_data = data;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
    endtask

    task automatic run_req(input int base, input logic [7:0] pins, input logic [1:0] keep,
                           input logic [1:0] set, input logic [1:0] exp, input string tag);
        req_valid = 1'b1;
        req_base  = 11'(base);
        req_pins  = pins;
        req_keep  = keep;
        req_set   = set;
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_valid === 1'b1 && res_bits === exp, tag, {res_valid, res_bits}, {1'b1, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
        chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);

        // Load the whole table from the reference functions.
        for (int g = 0; g < 13; g++)
            for (int idx = 0; idx < (1 << (2 * NIN[g])); idx++)
                tbl_write(BASES[g] + idx, ref_eval(g, idx));
        @(negedge clk);

        // R2 R4: directed vector table
        for (int v = 0; v < 11; v++)
            run_req(BASES[VEC[v][17:14]], VEC[v][13:6], VEC[v][5:4], VEC[v][3:2],
                    VEC[v][1:0], "R2/R4 vector");

        // R3: no result in an idle cycle
        @(negedge clk);
        chk(res_valid === 1'b0, "R3 idle", res_valid, 0);

        // R5: every gate, every combination, all three mask codes
        for (int g = 0; g < 13; g++)
            for (int idx = 0; idx < (1 << (2 * NIN[g])); idx++) begin
                logic [1:0] t;
                t = ref_eval(g, idx);
                run_req(BASES[g], 8'(idx), 2'b11, 2'b00, t, "R5 no-fault");
                run_req(BASES[g], 8'(idx), 2'b00, 2'b00, 2'b00, "R5 sa0");
                run_req(BASES[g], 8'(idx), 2'(idx), 2'b11, 2'b11, "R5 sa1");
            end

        // R6: overwrite an entry, read it back, restore it
        tbl_write(0, 2'b00);
        run_req(0, 8'h00, 2'b11, 2'b00, 2'b00, "R6 overwrite");
        tbl_write(0, 2'b11);
        run_req(0, 8'h00, 2'b11, 2'b00, 2'b11, "R6 restore");

        // R7: write and request in the same cycle
        tbl_wr_en = 1'b1; tbl_wr_addr = 11'd1; tbl_wr_data = 2'b01;
        req_valid = 1'b1; req_base = 11'd0; req_pins = 8'h01; req_keep = 2'b11; req_set = 2'b00;
        #1;
        chk(req_ready === 1'b0, "R7 ready low", req_ready, 0);
        @(negedge clk);
        tbl_wr_en = 1'b0;
        chk(res_valid === 1'b0, "R7 no result", res_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_valid === 1'b1 && res_bits === 2'b01, "R7 late accept",
            {res_valid, res_bits}, 3'b101);
        @(negedge clk);
        chk(res_valid === 1'b0, "R7 single result", res_valid, 0);
        tbl_write(1, 2'b10);

        // R8: indices at or past the table end read 00
        run_req(1347, 8'h01, 2'b11, 2'b00, 2'b00, "R8 one past end");
        run_req(2047, 8'hFF, 2'b11, 2'b00, 2'b00, "R8 far past end");
        run_req(2047, 8'hFF, 2'b00, 2'b11, 2'b11, "R8 set still applies");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule